// File: doc/BRIEF.md
# E1 CAS Timeslot-16 Signalling Inserter

This block assembles the timeslot-16 byte of a 2048 kbit/s E1 link (32 timeslots of 8 bits every 125 µs) that carries channel-associated signalling. The signalling multiframe has 16 frames. Frame 0 carries the multiframe alignment byte. Each of frames 1 to 15 carries the 4-bit ABCD code of two voice channels, so the multiframe covers 30 channels.

Each ABCD code comes from one of two sources, chosen by the `src_cpu` input. The first source is a bank of per-channel registers that a processor writes through a simple port. The second is a byte-wide serial signalling stream, tagged by timeslot, which packs two channel codes into each byte. Stream codes are collected in a shadow store. The shadow store is copied into the live store only at the start of a multiframe, so all 30 channels always change together. Framing logic outside the block gives the frame number and a latch strobe shortly before timeslot 16. The output byte is registered on that strobe.

Top module: `e1_ts16_sig_ins`

## Requirements
- R1: After reset, `ts16_out` is 0x0B. Every channel register and every live stream code holds ABCD = 1101. The alignment register holds 1011.
- R2: The processor port decodes `cpu_addr` as follows. Bit 4 is the page. Bits 3:0 are the offset k. Page 0 with k = 0..14 selects channel k+1. Page 1 with k = 0..14 selects channel k+16. A write stores `cpu_wdata[3:0]`. The read value `cpu_rdata` is combinational, has bits 7:4 at zero, and has bits 3:0 equal to the stored code.
- R3: Address 0x0F is the alignment register. Its bits 3:0 hold, from MSB to LSB: spare, alarm, spare, spare. Address 0x1F is unused: a write to it changes no register, and it reads as 0x00.
- R4: A cycle with `latch_en` high and `frame_num` = n in 1..15 loads `ts16_out` on that clock edge. When `src_cpu` = 1, `ts16_out[7:4]` is the register code of channel n and `ts16_out[3:0]` is the register code of channel n+15.
- R5: A latch with `frame_num` = 0 loads `ts16_out` = {0000, alignment register}, whatever the value of `src_cpu`.
- R6: `ts16_out` changes only on a clock edge where `latch_en` is high. Register writes and stream bytes between latches leave it unchanged.
- R7: When `half_sel` = 0, a stream byte with `st_valid` high and `st_ts` = t in 1..15 sets the shadow code of channel t to `st_byte[7:4]` and the shadow code of channel t+15 to `st_byte[3:0]`. Bytes on any other timeslot change nothing.
- R8: When `half_sel` = 1, timeslots t in 17..31 feed channels t-16 (from bits 7:4) and t-1 (from bits 3:0). Timeslots 0..16 change nothing.
- R9: The live stream codes take the value of the shadow store only on a latch with `frame_num` = 0. A latch for any other frame leaves the live codes unchanged.
- R10: When `src_cpu` = 0, frames 1..15 take their codes from the live stream store, with the same channel placement as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 5 | Register address: page in bit 4, offset in bits 3:0 |
| cpu_wdata | input | 8 | Write data; only bits 3:0 are stored |
| cpu_rdata | output | 8 | Read data for `cpu_addr` |
| src_cpu | input | 1 | 1: codes from the registers; 0: codes from the stream |
| half_sel | input | 1 | Selects which group of stream timeslots is captured |
| st_valid | input | 1 | A stream byte is present this cycle |
| st_ts | input | 5 | Timeslot number of the stream byte |
| st_byte | input | 8 | Stream byte carrying two ABCD codes |
| latch_en | input | 1 | Registers the TS16 byte for `frame_num` |
| frame_num | input | 4 | Multiframe frame number, 0..15 |
| ts16_out | output | 8 | Timeslot-16 byte for the current frame |

## Verification
A register write decoded to the wrong address shows up immediately as a wrong `cpu_rdata`. It also shows up later, in the wrong nibble of `ts16_out`, on the first latch of the affected frame. A stream capture error, or a shadow store applied at the wrong time, can only be seen after a frame-0 latch has taken place. For that reason the bench latches non-zero frames both before and after the boundary. An output register that loads outside the strobe is caught by a check a full cycle after the latch, and by the stability assertion.

// File: rtl/e1sig_pkg.sv
package e1sig_pkg;
    localparam int NIB       = 4;
    localparam int NCH_DEF   = 30;
    localparam logic [3:0] IDLE_ABCD = 4'b1101;
    localparam logic [3:0] ALIGN_RST = 4'b1011;

    function automatic logic [7:0] join_nibbles(input logic [3:0] hi, input logic [3:0] lo);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/e1sig_regbank.sv
module e1sig_regbank
    import e1sig_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int AW  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [7:0]           wdata,
    output logic [7:0]           rdata,
    output logic [NCH*NIB-1:0]   abcd_flat,
    output logic [3:0]           align_bits
);
    localparam int HALF = NCH / 2;
    localparam int OW   = AW - 1;

    typedef struct packed {
        logic [NCH*NIB-1:0] abcd;
        logic [3:0]         align;
    } bank_t;

    bank_t bank_d, bank_q;

    logic          page;
    logic [OW-1:0] off;
    assign page = addr[AW-1];
    assign off  = addr[OW-1:0];

    always_comb begin
        int idx;
        bank_d = bank_q;
        rdata  = 8'h00;
        idx    = (page ? HALF : 0) + int'(off);
        if (int'(off) < HALF) begin
            rdata = {4'b0000, bank_q.abcd[idx*NIB +: NIB]};
            if (we) bank_d.abcd[idx*NIB +: NIB] = wdata[3:0];
        end else if (int'(off) == HALF && !page) begin
            rdata = {4'b0000, bank_q.align};
            if (we) bank_d.align = wdata[3:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.abcd  <= {NCH{IDLE_ABCD}};
            bank_q.align <= ALIGN_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign abcd_flat  = bank_q.abcd;
    assign align_bits = bank_q.align;
endmodule

// File: rtl/e1sig_capture.sv
module e1sig_capture
    import e1sig_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int TSW = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic [TSW-1:0]     ts,
    input  logic [7:0]         data,
    input  logic               half_sel,
    input  logic               apply,
    output logic [NCH*NIB-1:0] live_flat
);
    localparam int HALF = NCH / 2;

    typedef struct packed {
        logic [NCH*NIB-1:0] shadow;
        logic [NCH*NIB-1:0] live;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        int  t;
        int  idx;
        logic hit;
        cap_d = cap_q;
        t     = int'(ts);
        idx   = 0;
        hit   = 1'b0;
        if (apply) cap_d.live = cap_q.shadow;
        if (!half_sel && t >= 1 && t <= HALF) begin
            hit = 1'b1;
            idx = t - 1;
        end else if (half_sel && t >= HALF + 2 && t <= 2 * HALF + 1) begin
            hit = 1'b1;
            idx = t - HALF - 2;
        end
        if (valid && hit) begin
            cap_d.shadow[idx*NIB +: NIB]          = data[7:4];
            cap_d.shadow[(idx + HALF)*NIB +: NIB] = data[3:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q.shadow <= {NCH{IDLE_ABCD}};
            cap_q.live   <= {NCH{IDLE_ABCD}};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign live_flat = cap_q.live;
endmodule

// File: rtl/e1sig_assemble.sv
module e1sig_assemble
    import e1sig_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int FW  = 4
) (
    input  logic [FW-1:0]      frame,
    input  logic               src_cpu,
    input  logic [NCH*NIB-1:0] cpu_flat,
    input  logic [NCH*NIB-1:0] st_flat,
    input  logic [3:0]         align_bits,
    output logic [7:0]         ts16_byte
);
    localparam int HALF = NCH / 2;

    logic [NCH*NIB-1:0] src;
    assign src = src_cpu ? cpu_flat : st_flat;

    always_comb begin
        int n;
        n = int'(frame);
        if (n == 0)
            ts16_byte = join_nibbles(4'b0000, align_bits);
        else if (n <= HALF)
            ts16_byte = join_nibbles(src[(n - 1)*NIB +: NIB], src[(n - 1 + HALF)*NIB +: NIB]);
        else
            ts16_byte = 8'h00;
    end
endmodule

// File: rtl/e1_ts16_sig_ins.sv
module e1_ts16_sig_ins
    import e1sig_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int AW  = 5,
    parameter int TSW = 5,
    parameter int FW  = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_we,
    input  logic [AW-1:0]  cpu_addr,
    input  logic [7:0]     cpu_wdata,
    output logic [7:0]     cpu_rdata,
    input  logic           src_cpu,
    input  logic           half_sel,
    input  logic           st_valid,
    input  logic [TSW-1:0] st_ts,
    input  logic [7:0]     st_byte,
    input  logic           latch_en,
    input  logic [FW-1:0]  frame_num,
    output logic [7:0]     ts16_out
);
    typedef struct packed {
        logic [7:0] ts16;
    } out_t;

    out_t out_d, out_q;

    logic [NCH*NIB-1:0] reg_flat;
    logic [NCH*NIB-1:0] live_flat;
    logic [3:0]         align_bits;
    logic [7:0]         next_byte;
    logic               mf_start;

    assign mf_start = latch_en && (frame_num == '0);

    e1sig_regbank #(.NCH(NCH), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(cpu_we), .addr(cpu_addr),
        .wdata(cpu_wdata), .rdata(cpu_rdata),
        .abcd_flat(reg_flat), .align_bits(align_bits)
    );

    e1sig_capture #(.NCH(NCH), .TSW(TSW)) u_cap (
        .clk(clk), .rst_n(rst_n), .valid(st_valid), .ts(st_ts),
        .data(st_byte), .half_sel(half_sel), .apply(mf_start),
        .live_flat(live_flat)
    );

    e1sig_assemble #(.NCH(NCH), .FW(FW)) u_asm (
        .frame(frame_num), .src_cpu(src_cpu), .cpu_flat(reg_flat),
        .st_flat(live_flat), .align_bits(align_bits), .ts16_byte(next_byte)
    );

    always_comb begin
        out_d = out_q;
        if (latch_en) out_d.ts16 = next_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q.ts16 <= {4'b0000, ALIGN_RST};
        else        out_q <= out_d;
    end

    assign ts16_out = out_q.ts16;
endmodule

// File: rtl/e1_ts16_sig_chk.sv
module e1_ts16_sig_chk #(
    parameter int W  = 120,
    parameter int FW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          latch_en,
    input logic [FW-1:0] frame_num,
    input logic [7:0]    ts16_out,
    input logic [7:0]    cpu_rdata,
    input logic [W-1:0]  live_flat
);
    assert_hold_between_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(ts16_out));

    assert_align_high_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && frame_num == '0) |=> (ts16_out[7:4] == 4'b0000));

    assert_live_only_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(latch_en && frame_num == '0) |=> $stable(live_flat));

    assert_read_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[7:4] == 4'b0000);
endmodule

bind e1_ts16_sig_ins e1_ts16_sig_chk #(.W(NCH*4), .FW(FW)) u_chk (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .frame_num(frame_num),
    .ts16_out(ts16_out), .cpu_rdata(cpu_rdata), .live_flat(live_flat)
);

// File: tb/e1_ts16_sig_ins_test.sv
`timescale 1ns/1ps
module e1_ts16_sig_ins_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_we = 1'b0;
    logic [4:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       src_cpu = 1'b1;
    logic       half_sel = 1'b0;
    logic       st_valid = 1'b0;
    logic [4:0] st_ts = '0;
    logic [7:0] st_byte = '0;
    logic       latch_en = 1'b0;
    logic [3:0] frame_num = '0;
    logic [7:0] ts16_out;

    int total = 0;
    int bad = 0;

    logic [3:0] reg_m [1:30];
    logic [3:0] shad_m [1:30];
    logic [3:0] live_m [1:30];
    logic [3:0] align_m;

    typedef struct { logic [7:0] val; string req; } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    e1_ts16_sig_ins uut (
        .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .src_cpu(src_cpu),
        .half_sel(half_sel), .st_valid(st_valid), .st_ts(st_ts),
        .st_byte(st_byte), .latch_en(latch_en), .frame_num(frame_num),
        .ts16_out(ts16_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
        if (a[3:0] < 4'd15) reg_m[(a[4] ? 16 : 1) + int'(a[3:0])] = d[3:0];
        else if (!a[4]) align_m = d[3:0];
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [7:0] exp);
        @(negedge clk);
        cpu_addr = a;
        #1 chk(req, cpu_rdata, exp);
    endtask

    task automatic stream(input logic [4:0] t, input logic [7:0] b);
        int ti;
        ti = int'(t);
        @(negedge clk);
        st_valid = 1'b1; st_ts = t; st_byte = b;
        @(negedge clk);
        st_valid = 1'b0;
        if (!half_sel && ti >= 1 && ti <= 15) begin
            shad_m[ti] = b[7:4]; shad_m[ti + 15] = b[3:0];
        end else if (half_sel && ti >= 17 && ti <= 31) begin
            shad_m[ti - 16] = b[7:4]; shad_m[ti - 1] = b[3:0];
        end
    endtask

    task automatic latch(input string req, input int f);
        exp_t e;
        @(negedge clk);
        latch_en = 1'b1; frame_num = f[3:0];
        if (f == 0) e.val = {4'b0000, align_m};
        else if (src_cpu) e.val = {reg_m[f], reg_m[f + 15]};
        else e.val = {live_m[f], live_m[f + 15]};
        e.req = req;
        @(negedge clk);
        latch_en = 1'b0;
        sb_q.push_back(e);
        if (f == 0) for (int i = 1; i <= 30; i++) live_m[i] = shad_m[i];
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #3;
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.req, ts16_out, e.val);
            end
        end
    end

    initial begin : watchdog
        #2000000;
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        for (int i = 1; i <= 30; i++) begin
            reg_m[i] = 4'b1101; shad_m[i] = 4'b1101; live_m[i] = 4'b1101;
        end
        align_m = 4'b1011;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 reset out", ts16_out, 8'h0B);
        rd("R1 reset ch1", 5'h00, 8'h0D);
        rd("R1 reset ch16", 5'h10, 8'h0D);
        rd("R1 reset align", 5'h0F, 8'h0B);

        wr(5'h00, 8'hF3);
        rd("R2 ch1 upper zero", 5'h00, 8'h03);
        wr(5'h0E, 8'h5A);
        rd("R2 ch15", 5'h0E, 8'h0A);
        wr(5'h10, 8'h07);
        rd("R2 ch16", 5'h10, 8'h07);
        wr(5'h1E, 8'h0C);
        rd("R2 ch30", 5'h1E, 8'h0C);

        wr(5'h1F, 8'h09);
        rd("R3 unused addr", 5'h1F, 8'h00);
        latch("R3 no side effect frame15", 15);
        wr(5'h0F, 8'hF4);
        rd("R3 align reg", 5'h0F, 8'h04);

        latch("R4 frame1 cpu", 1);
        latch("R4 frame2 cpu", 2);
        latch("R5 frame0 cpu", 0);
        src_cpu = 1'b0;
        latch("R5 frame0 stream", 0);
        src_cpu = 1'b1;

        latch("R6 before write", 1);
        wr(5'h00, 8'h00);
        stream(5'd1, 8'hEE);
        repeat (3) @(posedge clk);
        #2 chk("R6 held after write", ts16_out, 8'h37);
        latch("R6 relatch", 1);
        latch("R0 resync", 0);

        src_cpu = 1'b0;
        half_sel = 1'b0;
        stream(5'd1, 8'h12);
        stream(5'd16, 8'hFF);
        stream(5'd0, 8'hFF);
        stream(5'd20, 8'hFF);
        latch("R9 not yet applied", 1);
        latch("R9 boundary", 0);
        latch("R7 frame1 stream", 1);
        latch("R7 other ts ignored", 15);
        latch("R10 frame2 stream", 2);

        half_sel = 1'b1;
        stream(5'd17, 8'h9A);
        stream(5'd2, 8'h55);
        stream(5'd31, 8'h66);
        stream(5'd16, 8'h44);
        latch("R9 half1 pending", 1);
        latch("R9 half1 boundary", 0);
        latch("R8 ts17", 1);
        latch("R8 low ts ignored", 2);
        latch("R8 ts31", 15);
        src_cpu = 1'b1;
        latch("R10 back to cpu", 15);

        repeat (3) @(posedge clk);
        #4;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule